// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a group of already-synchronized GPIO input levels and raises a single interrupt request when any pin meets its programmed trigger condition. Each pin can be set to edge or level triggering. It has one enable for rising edges or high levels and another for falling edges or low levels. In edge mode a pin can also pass through a debounce filter, which accepts a new level only after it has been seen on two consecutive sample ticks.

Each pin that triggers sets a sticky pending flag. Software reads these flags through a small register bus and clears them by writing ones. The flags are combined into `irq_out`. `wake_req` reports a pending flag on any pin that still has at least one interrupt enable set. The debounce tick comes from a shared divider. Its period is a power of two, and it counts either system clock cycles or cycles of an external slow-clock enable.

Top module: `gpio_irq_detect`

## Requirements
- R1: The trigger register (offset 0x18) holds one bit per pin, and bit n belongs to pin n. A value of 0 makes the pin edge-triggered and a value of 1 makes it level-triggered.
- R2: In edge mode, enable-register (offset 0x1C) bit 16+n arms pin n for a low-to-high change, and bit n arms it for a high-to-low change. With debounce off, the flag is set on the second rising clock edge after the pin changes.
- R3: In level mode, the rising enable sets the flag on every cycle the pin is high, and the falling enable does so on every cycle the pin is low. A pin in level mode with both enables set never sets its flag.
- R4: In level mode, the pin's debounce enable (offset 0x14, bit n) is ignored, and the flag is set on the second clock edge after the level appears.
- R5: With debounce enabled in edge mode, a transition counts only if the new level is present on two consecutive debounce ticks. A pulse that does not span two ticks sets no flag.
- R6: The debounce control register (offset 0x24) holds a period exponent N in bits [3:0] and a source select in bit 4. A tick occurs once every 2^N counts. Source 0 counts system clock cycles, and source 1 counts cycles in which `slow_tick_en` is high.
- R7: The flag register (offset 0x20) reads 1 at bit n while pin n has a pending interrupt. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: If a set condition and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R9: `irq_out` is high exactly when at least one flag is pending.
- R10: `wake_req` is high when some pin has a pending flag and at least one of that pin's two enables is set.
- R11: Reset clears all configuration registers and flags and drives both outputs low.
- R12: Unimplemented register bits and unmapped offsets read as zero. The debounce control register reads back only bits [4:0], and the enable register reads back only bits [23:16] and [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Synchronized pin levels, one bit per pin |
| slow_tick_en | input | 1 | Slow-clock enable counted when debounce source 1 is selected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Wake-up request from a pending, still-enabled pin |

## Verification
The bench first walks a table of edge, level and mixed-mode patterns. It then attacks the corners. A clear that lands in the same cycle as a new trigger must lose, or an edge would be dropped. A level-mode flag cleared while its level persists must come straight back, or level interrupts would be lost. Level mode with both enables set must stay silent, where a loose design would fire every cycle. A one-cycle pulse, or a short pulse under a long tick period, must be rejected by the debounce filter, which a filter that ignored the period or the second sample would let through. The bench also holds the slow source idle to confirm that it gates acceptance, and checks that clearing a pin's enables drops `wake_req` while `irq_out` stays high.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO interrupt detector: register offsets,
// field positions and bus widths. Assumes byte offsets on an 8-bit bus.
package gpio_irq_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned PER_W    = 4;   // width of the tick exponent field
    localparam int unsigned RISE_LSB = 16;  // rising/high enables start here

    localparam logic [ADDR_W-1:0] OFS_DBEN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_FLAG  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_DBCTL = 8'h24;

    // Debounce control fields as held in the register block.
    typedef struct packed {
        logic             src_slow;
        logic [PER_W-1:0] period;
    } dbctl_t;
endpackage

// File: rtl/gpio_irq_regs.sv
// Configuration register file and read mux for the pin interrupt detector.
// Assumes single-cycle writes and combinational reads; the flag register
// lives in the pin slices, this block only decodes its write-1-to-clear.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPIN-1:0]   flags_in,
    output logic [NPIN-1:0]   mode_q,
    output logic [NPIN-1:0]   dben_q,
    output logic [NPIN-1:0]   en_rise_q,
    output logic [NPIN-1:0]   en_fall_q,
    output dbctl_t            dbctl_q,
    output logic [NPIN-1:0]   clr_mask,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned CTL_W = PER_W + 1;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wdata;

    // Hold the configuration registers; cleared by reset, loaded on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            dben_q    <= '0;
            en_rise_q <= '0;
            en_fall_q <= '0;
            dbctl_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_MODE:  mode_q  <= wdata[NPIN-1:0];
                OFS_DBEN:  dben_q  <= wdata[NPIN-1:0];
                OFS_IEN: begin
                    en_rise_q <= wdata[RISE_LSB +: NPIN];
                    en_fall_q <= wdata[NPIN-1:0];
                end
                OFS_DBCTL: dbctl_q <= dbctl_t'(wdata[CTL_W-1:0]);
                default:   ;
            endcase
        end
    end

    // Decode the write-1-to-clear strobe for the pending flags.
    always_comb begin
        clr_mask = '0;
        if (wr_en && addr == OFS_FLAG) begin
            clr_mask = wdata[NPIN-1:0];
        end
    end

    // Select read data by offset; unmapped bits and offsets read zero.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_MODE:  rdata[NPIN-1:0] = mode_q;
            OFS_DBEN:  rdata[NPIN-1:0] = dben_q;
            OFS_IEN: begin
                rdata[RISE_LSB +: NPIN] = en_rise_q;
                rdata[NPIN-1:0]         = en_fall_q;
            end
            OFS_FLAG:  rdata[NPIN-1:0]  = flags_in;
            OFS_DBCTL: rdata[CTL_W-1:0] = dbctl_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_tick.sv
// Shared debounce tick divider. One tick is emitted every 2^period counts,
// where a count is a system clock cycle or a cycle with the slow enable high.
// Assumes the slow enable is already synchronous to clk.
module gpio_irq_tick
    import gpio_irq_pkg::*;
#(
    parameter int unsigned EXP_W = PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] period,
    input  logic             src_slow,
    input  logic             slow_en,
    output logic             tick
);
    localparam int unsigned CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic             step;

    // Choose what counts as one step of the divider.
    always_comb step = src_slow ? slow_en : 1'b1;

    // Low-order bits that must all be ones for a tick.
    always_comb mask = (CNT_W'(1) << period) - CNT_W'(1);

    // Tick on the step that completes a block of 2^period steps.
    always_comb tick = step && ((cnt_q & mask) == mask);

    // Free-running step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/gpio_irq_pin.sv
// One pin slice: input sampling, optional two-tick debounce, edge/level
// trigger decode and the sticky pending flag. Assumes pin_lvl is already
// synchronized; the debounce filter tracks the raw level while disabled so
// turning it on never produces a spurious edge.
module gpio_irq_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_lvl,
    input  logic lvl_mode,
    input  logic db_on,
    input  logic arm_rise,
    input  logic arm_fall,
    input  logic tick,
    input  logic clr,
    output logic flag
);
    logic cur_q, old_q, cand_q, stable_q, flag_q;
    logic accept, rise_ev, fall_ev, level_hit, set_cond;

    // Sample the pin once per clock and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= 1'b0;
            old_q <= 1'b0;
        end else begin
            cur_q <= pin_lvl;
            old_q <= cur_q;
        end
    end

    // The new level must match the candidate taken on the previous tick.
    always_comb accept = db_on && tick && (cur_q == cand_q) && (cur_q != stable_q);

    // Debounce state: follow the raw level when off, sample on ticks when on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q   <= 1'b0;
            stable_q <= 1'b0;
        end else if (!db_on) begin
            cand_q   <= cur_q;
            stable_q <= cur_q;
        end else if (tick) begin
            cand_q <= cur_q;
            if (accept) begin
                stable_q <= cur_q;
            end
        end
    end

    // Edge events from the raw samples or from the debounced level.
    always_comb begin
        if (db_on) begin
            rise_ev = accept &&  cur_q;
            fall_ev = accept && !cur_q;
        end else begin
            rise_ev =  cur_q && !old_q;
            fall_ev = !cur_q &&  old_q;
        end
    end

    // Level condition: exactly one polarity armed and the pin at that level.
    always_comb level_hit = (arm_rise ^ arm_fall) && (arm_rise ? cur_q : !cur_q);

    // Pick the trigger source by mode.
    always_comb begin
        if (lvl_mode) begin
            set_cond = level_hit;
        end else begin
            set_cond = (arm_rise && rise_ev) || (arm_fall && fall_ev);
        end
    end

    // Sticky flag: a new trigger takes priority over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= set_cond || (flag_q && !clr);
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/gpio_irq_detect.sv
// Top of the GPIO pin interrupt detector: register file, shared debounce
// tick and one slice per pin, with the flags folded into irq and wake.
// Assumes pin_in and slow_tick_en are synchronous to clk.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_in,
    input  logic              slow_tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              wake_req
);
    logic [NPIN-1:0] mode_q, dben_q, en_rise_q, en_fall_q, clr_mask, flag_q;
    dbctl_t          dbctl_q;
    logic            tick;

    gpio_irq_regs #(.NPIN(NPIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .flags_in  (flag_q),
        .mode_q    (mode_q),
        .dben_q    (dben_q),
        .en_rise_q (en_rise_q),
        .en_fall_q (en_fall_q),
        .dbctl_q   (dbctl_q),
        .clr_mask  (clr_mask),
        .rdata     (reg_rdata)
    );

    gpio_irq_tick #(.EXP_W(PER_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .period   (dbctl_q.period),
        .src_slow (dbctl_q.src_slow),
        .slow_en  (slow_tick_en),
        .tick     (tick)
    );

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_lvl  (pin_in[gi]),
            .lvl_mode (mode_q[gi]),
            .db_on    (dben_q[gi]),
            .arm_rise (en_rise_q[gi]),
            .arm_fall (en_fall_q[gi]),
            .tick     (tick),
            .clr      (clr_mask[gi]),
            .flag     (flag_q[gi])
        );
    end

    // Combine pending flags into the interrupt and wake-up requests.
    always_comb begin
        irq_out  = |flag_q;
        wake_req = |(flag_q & (en_rise_q | en_fall_q));
    end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
// Property checker for the pin interrupt detector, bound onto the top.
// Observes the register outputs, tick, flags and the block outputs.
module gpio_irq_detect_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NPIN-1:0]   clr_bits,
    input logic [NPIN-1:0]   flags,
    input logic [NPIN-1:0]   mode,
    input logic [NPIN-1:0]   en_rise,
    input logic [NPIN-1:0]   en_fall,
    input logic [PER_W-1:0]  per,
    input logic              src_slow,
    input logic              tick,
    input logic              irq_out,
    input logic              wake_req
);
    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin_chk
        // R7: a flag only drops after a write of 1 to its bit
        p_clear_needs_w1_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[gi]) |-> $past(reg_wr && reg_addr == OFS_FLAG && clr_bits[gi]));
        // R3: level mode with both polarities armed never raises a flag
        p_both_level_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[gi]) |-> $past(!(mode[gi] && en_rise[gi] && en_fall[gi])));
        // R2: a flag only rises on a pin with some enable armed
        p_rise_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[gi]) |-> $past(en_rise[gi] || en_fall[gi]));
    end

    // R6: exponent 0 on the system clock ticks on every cycle
    p_tick_every_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (per == '0 && !src_slow) |-> tick);

    // R10: a wake request always comes with an interrupt request
    p_wake_implies_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> irq_out);
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPIN(NPIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .clr_bits (reg_wdata[NPIN-1:0]),
    .flags    (flag_q),
    .mode     (mode_q),
    .en_rise  (en_rise_q),
    .en_fall  (en_fall_q),
    .per      (dbctl_q.period),
    .src_slow (dbctl_q.src_slow),
    .tick     (tick),
    .irq_out  (irq_out),
    .wake_req (wake_req)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
    localparam logic [7:0] A_DBEN = 8'h14, A_MODE = 8'h18, A_IEN = 8'h1C,
                           A_FLAG = 8'h20, A_DBCTL = 8'h24;

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] rise;
        logic [7:0] fall;
        logic [7:0] lvl0;
        logic [7:0] lvl1;
        logic [7:0] exp;
    } vec_t;

    // mode, rise en, fall en, level before, level after, expected flags
    localparam vec_t VECS [8] = '{
        '{8'h00, 8'hFF, 8'h00, 8'h00, 8'hA5, 8'hA5},  // R2 rising edges
        '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h3C, 8'hC3},  // R2 falling edges
        '{8'h00, 8'hFF, 8'hFF, 8'h0F, 8'hF0, 8'hFF},  // R2 both edges
        '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h5A, 8'h5A},  // R3 level high
        '{8'hFF, 8'h00, 8'hFF, 8'h00, 8'h5A, 8'hA5},  // R3 level low
        '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h5A, 8'h00},  // R3 both armed: silent
        '{8'h0F, 8'h0F, 8'hF0, 8'hC0, 8'h0C, 8'hCC},  // R1 mixed per-pin modes
        '{8'h00, 8'hFF, 8'h00, 8'h55, 8'h55, 8'h00}   // R2 no change, no flag
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = '0;
    logic        slow_tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out, wake_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_detect u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_in       (pin_in),
        .slow_tick_en (slow_tick_en),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_out      (irq_out),
        .wake_req     (wake_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cleanup();
        wr(A_IEN, 0);
        pin_in = '0;
        slow_tick_en = 1'b0;
        cyc(3);
        wr(A_FLAG, 32'hFF);
        wr(A_MODE, 0);
        wr(A_DBEN, 0);
        wr(A_DBCTL, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R11: reset state
        chk("R11 irq after reset", {31'b0, irq_out}, 0);
        chk("R11 wake after reset", {31'b0, wake_req}, 0);
        foreach (VECS[k]) begin end
        rd(A_MODE, d);  chk("R11 mode reg", d, 0);
        rd(A_IEN, d);   chk("R11 enable reg", d, 0);
        rd(A_FLAG, d);  chk("R11 flag reg", d, 0);
        rd(A_DBCTL, d); chk("R11 dbctl reg", d, 0);

        // R12: readback widths and unmapped offset
        wr(A_DBCTL, 32'hFFFF_FFFF);
        rd(A_DBCTL, d); chk("R12 dbctl readback", d, 32'h1F);
        wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, d);   chk("R12 enable readback", d, 32'h00FF_00FF);
        rd(8'h28, d);   chk("R12 unmapped offset", d, 0);
        cleanup();

        // Table walk: enables arrive in the same cycle as the new level.
        for (int i = 0; i < 8; i++) begin
            pin_in = VECS[i].lvl0;
            cyc(3);
            wr(A_FLAG, 32'hFF);
            wr(A_MODE, {24'b0, VECS[i].mode});
            reg_wr = 1'b1; reg_addr = A_IEN;
            reg_wdata = {8'b0, VECS[i].rise, 8'b0, VECS[i].fall};
            pin_in = VECS[i].lvl1;
            @(posedge clk); @(negedge clk);
            reg_wr = 1'b0;
            cyc(1);
            rd(A_FLAG, d);
            chk($sformatf("R1 vector %0d flags", i), d, {24'b0, VECS[i].exp});
            chk($sformatf("R9 vector %0d irq", i), {31'b0, irq_out}, {31'b0, VECS[i].exp != 0});
            chk($sformatf("R10 vector %0d wake", i), {31'b0, wake_req}, {31'b0, VECS[i].exp != 0});
            wr(A_IEN, 0);
        end
        cleanup();

        // R7: write-1-to-clear, write 0 has no effect
        wr(A_IEN, 32'h00FF_0000);
        pin_in = 8'hFF;
        cyc(3);
        rd(A_FLAG, d); chk("R7 all flags set", d, 32'hFF);
        wr(A_FLAG, 32'h0F);
        rd(A_FLAG, d); chk("R7 partial clear", d, 32'hF0);
        wr(A_FLAG, 32'h00);
        rd(A_FLAG, d); chk("R7 write zero ignored", d, 32'hF0);
        wr(A_FLAG, 32'hF0);
        rd(A_FLAG, d); chk("R7 full clear", d, 0);
        chk("R9 irq low when clear", {31'b0, irq_out}, 0);
        cleanup();

        // R8: set and clear in the same cycle -> set wins
        wr(A_IEN, 32'h0001_0000);
        pin_in = 8'h01;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_FLAG; reg_wdata = 32'h01;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
        rd(A_FLAG, d); chk("R8 set beats clear", d, 32'h01);
        wr(A_FLAG, 32'h01);
        rd(A_FLAG, d); chk("R8 later clear works", d, 0);
        cleanup();

        // R3: level flag returns while level persists
        wr(A_MODE, 32'h01);
        wr(A_IEN, 32'h0001_0000);
        pin_in = 8'h01;
        cyc(2);
        rd(A_FLAG, d); chk("R3 level flag set", d, 32'h01);
        wr(A_FLAG, 32'h01);
        rd(A_FLAG, d); chk("R3 level flag re-set", d, 32'h01);
        pin_in = 8'h00;
        cyc(2);
        wr(A_FLAG, 32'h01);
        rd(A_FLAG, d); chk("R3 level flag cleared after drop", d, 0);
        cleanup();

        // R4: level mode ignores debounce, two-edge latency
        wr(A_DBEN, 32'hFF);
        wr(A_DBCTL, 32'h0F);
        wr(A_MODE, 32'hFF);
        wr(A_IEN, 32'h00FF_0000);
        pin_in = 8'h0F;
        cyc(1);
        rd(A_FLAG, d); chk("R4 not yet after one edge", d, 0);
        cyc(1);
        rd(A_FLAG, d); chk("R4 level set despite debounce", d, 32'h0F);
        cleanup();

        // R5: one-cycle pulse rejected at tick-per-cycle; hold accepted
        wr(A_DBEN, 32'h01);
        wr(A_IEN, 32'h0001_0000);
        pin_in = 8'h01;
        cyc(1);
        pin_in = 8'h00;
        cyc(6);
        rd(A_FLAG, d); chk("R5 short pulse rejected", d, 0);
        pin_in = 8'h01;
        cyc(2);
        rd(A_FLAG, d); chk("R5 not before second tick", d, 0);
        cyc(1);
        rd(A_FLAG, d); chk("R5 accepted on second tick", d, 32'h01);
        cleanup();

        // R6: period 2^3 rejects a three-cycle pulse, accepts a long hold
        wr(A_DBEN, 32'h01);
        wr(A_DBCTL, 32'h03);
        wr(A_IEN, 32'h0001_0000);
        pin_in = 8'h01;
        cyc(3);
        pin_in = 8'h00;
        cyc(20);
        rd(A_FLAG, d); chk("R6 pulse shorter than period rejected", d, 0);
        pin_in = 8'h01;
        cyc(30);
        rd(A_FLAG, d); chk("R6 long hold accepted", d, 32'h01);
        cleanup();

        // R6: slow source gates the debounce ticks
        wr(A_DBEN, 32'h01);
        wr(A_DBCTL, 32'h10);
        wr(A_IEN, 32'h0001_0000);
        pin_in = 8'h01;
        cyc(12);
        rd(A_FLAG, d); chk("R6 slow source idle, no accept", d, 0);
        slow_tick_en = 1'b1;
        cyc(4);
        rd(A_FLAG, d); chk("R6 slow source ticking, accepted", d, 32'h01);

        // R10: disabling enables drops wake but not irq
        chk("R10 wake with enabled flag", {31'b0, wake_req}, 1);
        wr(A_IEN, 0);
        chk("R10 wake drops with enables off", {31'b0, wake_req}, 0);
        chk("R9 irq stays with flag pending", {31'b0, irq_out}, 1);

        // R11: reset in the middle of activity
        rst_n = 1'b0;
        cyc(1);
        rst_n = 1'b1;
        rd(A_FLAG, d);  chk("R11 flags after mid reset", d, 0);
        rd(A_DBCTL, d); chk("R11 dbctl after mid reset", d, 0);
        chk("R11 irq after mid reset", {31'b0, irq_out}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule